// File: doc/BRIEF.md
# Two-Wire Register Slave with Interrupt

This block is the control-plane front end of a four-port power controller. It exposes a small register file on a two-wire serial bus. Data comes in on one pin and goes out on another, and the output pin only pulls low. The device address is fixed in its upper three bits. A 4-bit strap sets the lower four bits, so several controllers can share one bus. Port logic elsewhere on the chip reports events as single-cycle pulses. The block latches each event in a sticky event register. A mask register selects which events may pull the active-low, open-drain interrupt line.

A host sets the register pointer, then either writes one data byte or issues a repeated start and reads one byte back. A read sent straight after a start returns the event register, which saves the pointer phase when servicing an interrupt. The alert-response address is also answered: the reply is the block's own address byte. The interrupt line is frozen while a transfer is in progress. Any change is applied only after the stop condition. Writes to a pushbutton register release the line, clear the events, or request a reset of all ports.

Top module: `pse_i2c_regs`

## Requirements
- R1: The slave responds only to the 7-bit address formed by binary 010 followed by strap bits 3 down to 0. Any other address byte, except the alert-response address read, gets no acknowledge, and the rest of that transfer has no effect.
- R2: A write is address byte with R/W=0, register-address byte, data byte, then stop. The slave acknowledges all three bytes and the data lands in the addressed register. The mask register sits at 0x01 and reads back what was written.
- R3: A read is start, address byte with R/W=0, register-address byte, repeated start, address byte with R/W=1. The slave then returns one byte MSB first. After the master's not-acknowledge the slave leaves SDA released.
- R4: A read whose transfer carried no register-address byte since its start returns the event register, which is at 0x00.
- R5: Each event bit is set by a one-cycle pulse on its evt_pulse input, whatever the mask holds. It stays set until cleared by bit 7 of the pushbutton register.
- R6: An event pulse on a bit whose mask bit is 1 asserts irq_pull_low. A pulse on a bit whose mask bit is 0 does not.
- R7: irq_pull_low changes only while the bus is idle. A change requested between a start and its stop, by a new event or by a release write, takes effect only after the stop.
- R8: Writing the pushbutton register at 0x1A with bit 6 set releases the interrupt line and leaves the event bits unchanged.
- R9: Writing 0x1A with bit 7 set clears every event bit and releases the interrupt line.
- R10: Writing 0x1A with bit 4 set produces a one-cycle pulse on port_reset_all.
- R11: A read addressed to 0001100 (byte 0x19) is acknowledged. The slave replies with 010, the four strap bits, then a 1.
- R12: A write to an unimplemented register, or to the read-only event register, is acknowledged and discarded. Unimplemented registers and 0x1A read as 0x00.
- R13: After reset, SDA and the interrupt line are released, port_reset_all is low, the event register is 0x00 and the mask is MASK_INIT (default 0x00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_pull_low | output | 1 | 1 pulls the bus data line low (open-drain data out) |
| strap_addr | input | 4 | Strap value for the low four address bits |
| evt_pulse | input | EVT_W | One-cycle event pulses from port logic |
| irq_pull_low | output | 1 | 1 pulls the active-low interrupt line low |
| port_reset_all | output | 1 | One-cycle request to reset all ports |

## Verification
The assertions assume a single, well-behaved bus master. SCL phases must last several system clocks, and SDA may move only while SCL is low, except at start and stop conditions. Event inputs must be single-cycle pulses. The bench master holds each SCL phase for ten clocks. It changes SDA two clocks after SCL falls, so SDA is never near an SCL edge. It models the open-drain line as the AND of its own drive and the slave's release, and it pulses events only on falling clock edges.

// File: rtl/pse_i2c_pkg.sv
package pse_i2c_pkg;
  localparam logic [2:0] DEV_ADDR_HI = 3'b010;
  localparam logic [6:0] ALERT_ADDR  = 7'b0001100;

  localparam logic [7:0] REG_EVENT  = 8'h00;
  localparam logic [7:0] REG_MASK   = 8'h01;
  localparam logic [7:0] REG_BUTTON = 8'h1A;

  localparam int BTN_CLR_ALL  = 7;
  localparam int BTN_CLR_PIN  = 6;
  localparam int BTN_PORT_RST = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK_WAIT, ST_ACK_HOLD} slv_state_t;
  typedef enum logic [1:0] {RX_DEV, RX_REG, RX_DATA} rx_kind_t;
endpackage

// File: rtl/pse_i2c_line_sync.sv
module pse_i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/pse_i2c_sequencer.sv
module pse_i2c_sequencer
  import pse_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] strap_addr,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_addr,
  output logic       wr_stb,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sda_pull_low,
  output logic       busy
);
  slv_state_t state;
  rx_kind_t   rx_kind;
  logic [2:0] bitcnt;
  logic [6:0] sh;
  logic [7:0] tx_sh;
  logic [7:0] ptr;
  logic       ptr_vld;
  logic       go_tx;
  logic       tx_on;

  logic [7:0] rx_byte;
  logic       own_hit, ara_hit;

  assign rx_byte = {sh, sda_s};
  assign own_hit = (rx_byte[7:1] == {DEV_ADDR_HI, strap_addr});
  assign ara_hit = (rx_byte[7:1] == ALERT_ADDR) && rx_byte[0];
  assign rd_addr = ptr_vld ? ptr : REG_EVENT;
  assign wr_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      rx_kind      <= RX_DEV;
      bitcnt       <= '0;
      sh           <= '0;
      tx_sh        <= '0;
      ptr          <= '0;
      ptr_vld      <= 1'b0;
      go_tx        <= 1'b0;
      tx_on        <= 1'b0;
      wr_stb       <= 1'b0;
      wr_data      <= '0;
      sda_pull_low <= 1'b0;
      busy         <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        if (!busy) ptr_vld <= 1'b0;
        busy         <= 1'b1;
        state        <= ST_RX;
        rx_kind      <= RX_DEV;
        bitcnt       <= '0;
        tx_on        <= 1'b0;
        sda_pull_low <= 1'b0;
      end else if (stop_det) begin
        busy         <= 1'b0;
        state        <= ST_IDLE;
        tx_on        <= 1'b0;
        sda_pull_low <= 1'b0;
      end else if (tx_on) begin
        // transmit: bit counter wraps to zero after the eighth SCL rise
        if (scl_rise) bitcnt <= bitcnt + 3'd1;
        if (scl_fall) begin
          if (bitcnt == 3'd0) begin
            sda_pull_low <= 1'b0;
            tx_on        <= 1'b0;
            state        <= ST_IDLE;
          end else begin
            tx_sh        <= {tx_sh[6:0], 1'b0};
            sda_pull_low <= ~tx_sh[6];
          end
        end
      end else begin
        unique case (state)
          ST_RX: if (scl_rise) begin
            sh     <= rx_byte[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              state <= ST_ACK_WAIT;
              go_tx <= 1'b0;
              unique case (rx_kind)
                RX_DEV: begin
                  if (own_hit && !rx_byte[0]) begin
                    rx_kind <= RX_REG;
                  end else if (own_hit) begin
                    go_tx <= 1'b1;
                    tx_sh <= rd_data;
                  end else if (ara_hit) begin
                    go_tx <= 1'b1;
                    tx_sh <= {DEV_ADDR_HI, strap_addr, 1'b1};
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                RX_REG: begin
                  ptr     <= rx_byte;
                  ptr_vld <= 1'b1;
                  rx_kind <= RX_DATA;
                end
                default: begin
                  wr_stb  <= 1'b1;
                  wr_data <= rx_byte;
                end
              endcase
            end
          end
          ST_ACK_WAIT: if (scl_fall) begin
            sda_pull_low <= 1'b1;
            state        <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: if (scl_fall) begin
            bitcnt <= '0;
            if (go_tx) begin
              tx_on        <= 1'b1;
              sda_pull_low <= ~tx_sh[7];
            end else begin
              sda_pull_low <= 1'b0;
              state        <= ST_RX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pse_irq_regs.sv
module pse_irq_regs
  import pse_i2c_pkg::*;
#(
  parameter int         EVT_W     = 8,
  parameter logic [7:0] MASK_INIT = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] evt_pulse,
  input  logic             wr_stb,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_addr,
  input  logic             bus_busy,
  output logic [7:0]       rd_data,
  output logic [EVT_W-1:0] event_bits,
  output logic             irq_req,
  output logic             irq_pull_low,
  output logic             port_reset_all
);
  logic [EVT_W-1:0] mask_q;
  logic btn_wr, clr_evt, clr_pin, mask_wr;

  assign btn_wr  = wr_stb && (wr_addr == REG_BUTTON);
  assign mask_wr = wr_stb && (wr_addr == REG_MASK);
  assign clr_evt = btn_wr && wr_data[BTN_CLR_ALL];
  assign clr_pin = btn_wr && (wr_data[BTN_CLR_ALL] || wr_data[BTN_CLR_PIN]);

  for (genvar g = 0; g < EVT_W; g++) begin : g_evt
    always_ff @(posedge clk) begin
      if (rst)               event_bits[g] <= 1'b0;
      else if (evt_pulse[g]) event_bits[g] <= 1'b1;
      else if (clr_evt)      event_bits[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q         <= MASK_INIT[EVT_W-1:0];
      irq_req        <= 1'b0;
      irq_pull_low   <= 1'b0;
      port_reset_all <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= wr_data[EVT_W-1:0];
      if (|(evt_pulse & mask_q)) irq_req <= 1'b1;
      else if (clr_pin)          irq_req <= 1'b0;
      if (!bus_busy) irq_pull_low <= irq_req;
      port_reset_all <= btn_wr && wr_data[BTN_PORT_RST];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == REG_EVENT)     rd_data[EVT_W-1:0] = event_bits;
    else if (rd_addr == REG_MASK) rd_data[EVT_W-1:0] = mask_q;
  end
endmodule

// File: rtl/pse_i2c_regs.sv
module pse_i2c_regs #(
  parameter int         EVT_W       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] MASK_INIT   = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_low,
  input  logic [3:0]       strap_addr,
  input  logic [EVT_W-1:0] evt_pulse,
  output logic             irq_pull_low,
  output logic             port_reset_all
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, wr_stb, irq_req;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  logic [EVT_W-1:0] event_bits;

  pse_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  pse_i2c_sequencer u_seq (
    .clk(clk), .rst(rst), .strap_addr(strap_addr), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .sda_pull_low(sda_pull_low), .busy(busy)
  );

  pse_irq_regs #(.EVT_W(EVT_W), .MASK_INIT(MASK_INIT)) u_regs (
    .clk(clk), .rst(rst), .evt_pulse(evt_pulse), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .bus_busy(busy), .rd_data(rd_data),
    .event_bits(event_bits), .irq_req(irq_req), .irq_pull_low(irq_pull_low),
    .port_reset_all(port_reset_all)
  );
endmodule

// File: rtl/pse_i2c_regs_chk.sv
module pse_i2c_regs_chk #(
  parameter int EVT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_s,
  input logic             busy,
  input logic             sda_pull_low,
  input logic             irq_pull_low,
  input logic             port_reset_all,
  input logic [EVT_W-1:0] event_bits
);
  a_r13_reset_released: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_pull_low && !irq_pull_low && !port_reset_all));

  a_r10_port_reset_single: assert property (@(posedge clk) disable iff (rst)
    port_reset_all |=> !port_reset_all);

  a_r7_irq_frozen_in_txn: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(irq_pull_low));

  a_r6_irq_rise_has_event: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pull_low) |-> ($past(event_bits) != '0));

  // R2: the slave only starts pulling the data line while SCL is low
  a_r2_pull_starts_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_low) |-> !$past(scl_s));
endmodule

bind pse_i2c_regs pse_i2c_regs_chk #(.EVT_W(EVT_W)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .busy(busy), .sda_pull_low(sda_pull_low),
  .irq_pull_low(irq_pull_low), .port_reset_all(port_reset_all), .event_bits(event_bits)
);

// File: tb/test_pse_i2c_regs.sv
module test_pse_i2c_regs;
  localparam int Q = 10;
  localparam logic [3:0] STRAP = 4'b1010;
  localparam logic [7:0] WR_B = {3'b010, STRAP, 1'b0};
  localparam logic [7:0] RD_B = {3'b010, STRAP, 1'b1};

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [7:0] evt = '0;
  logic sda_pull_low, irq_pull_low, port_reset_all;
  logic sda_line;
  int checks = 0, failures = 0, prst_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull_low;
  always @(posedge clk) if (port_reset_all) prst_cnt <= prst_cnt + 1;

  pse_i2c_regs i_pse_i2c_regs (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_low(sda_pull_low),
    .strap_addr(STRAP), .evt_pulse(evt), .irq_pull_low(irq_pull_low),
    .port_reset_all(port_reset_all)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1; scl_m = 1; wait_clk(Q); sda_m = 0; wait_clk(Q); scl_m = 0; wait_clk(Q);
  endtask
  task automatic bus_rstart;
    sda_m = 1; wait_clk(Q); scl_m = 1; wait_clk(Q); sda_m = 0; wait_clk(Q); scl_m = 0; wait_clk(Q);
  endtask
  task automatic bus_stop;
    sda_m = 0; wait_clk(Q); scl_m = 1; wait_clk(Q); sda_m = 1; wait_clk(Q);
  endtask

  task automatic bus_send(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clk(Q); scl_m = 1; wait_clk(Q); scl_m = 0; wait_clk(2);
    end
    sda_m = 1; wait_clk(Q); scl_m = 1; wait_clk(Q/2); acked = ~sda_line;
    wait_clk(Q/2); scl_m = 0; wait_clk(2);
  endtask

  task automatic bus_recv(output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(Q); scl_m = 1; wait_clk(Q/2); b[i] = sda_line; wait_clk(Q/2); scl_m = 0; wait_clk(2);
    end
    sda_m = 1; wait_clk(Q); scl_m = 1; wait_clk(Q); scl_m = 0; wait_clk(2);
  endtask

  task automatic reg_write(input logic [7:0] ra, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start; bus_send(WR_B, a0); bus_send(ra, a1); bus_send(d, a2); bus_stop;
    ok = a0 & a1 & a2;
  endtask

  task automatic reg_read(input logic [7:0] ra, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start; bus_send(WR_B, a0); bus_send(ra, a1);
    bus_rstart; bus_send(RD_B, a2); bus_recv(d); bus_stop;
    ok = a0 & a1 & a2;
  endtask

  task automatic short_read(output logic [7:0] d);
    logic a0;
    bus_start; bus_send(RD_B, a0); bus_recv(d); bus_stop;
    check("R4 short-form ack", a0, 1'b1);
  endtask

  task automatic pulse_evt(input logic [7:0] m);
    @(negedge clk); evt = m; @(negedge clk); evt = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic ok;
    check("R13 sda released", sda_pull_low, 1'b0);
    check("R13 irq released", irq_pull_low, 1'b0);
    check("R13 port reset low", port_reset_all, 1'b0);
    reg_read(8'h01, d, ok);
    check("R13 mask init", d, 8'h00);
    short_read(d);
    check("R13 event clear", d, 8'h00);
  endtask

  task automatic t_write_read;
    logic [7:0] d; logic ok;
    reg_write(8'h01, 8'hA5, ok);
    check("R2 write acked", ok, 1'b1);
    reg_read(8'h01, d, ok);
    check("R3 read acked", ok, 1'b1);
    check("R3 read data", d, 8'hA5);
    check("R3 sda released after nack", sda_pull_low, 1'b0);
  endtask

  task automatic t_bad_addr;
    logic a0, a1, a2; logic [7:0] d; logic ok;
    bus_start; bus_send(8'h56, a0); bus_send(8'h01, a1); bus_send(8'h00, a2); bus_stop;
    check("R1 foreign address not acked", a0, 1'b0);
    reg_read(8'h01, d, ok);
    check("R1 foreign write ignored", d, 8'hA5);
  endtask

  task automatic t_unimpl;
    logic [7:0] d; logic ok;
    reg_write(8'h05, 8'h3C, ok);
    check("R12 unimplemented write acked", ok, 1'b1);
    reg_read(8'h05, d, ok);
    check("R12 unimplemented reads zero", d, 8'h00);
    reg_write(8'h00, 8'hFF, ok);
    check("R12 event write acked", ok, 1'b1);
    short_read(d);
    check("R12 event write discarded", d, 8'h00);
    reg_read(8'h01, d, ok);
    check("R12 mask untouched", d, 8'hA5);
  endtask

  task automatic t_events;
    logic [7:0] d; logic ok;
    pulse_evt(8'h02); wait_clk(5);
    check("R6 masked-off event no irq", irq_pull_low, 1'b0);
    short_read(d);
    check("R5 masked-off event latched", d, 8'h02);
    pulse_evt(8'h04); wait_clk(5);
    check("R6 enabled event irq", irq_pull_low, 1'b1);
    short_read(d);
    check("R4 short read event reg", d, 8'h06);
    check("R6 irq held after read", irq_pull_low, 1'b1);
    reg_write(8'h1A, 8'h40, ok); wait_clk(5);
    check("R8 bit6 releases irq", irq_pull_low, 1'b0);
    short_read(d);
    check("R8 events kept", d, 8'h06);
  endtask

  task automatic t_in_txn;
    logic a0, a1, a2; logic [7:0] d;
    bus_start; bus_send(WR_B, a0);
    pulse_evt(8'h01); wait_clk(20);
    check("R7 irq frozen during transfer", irq_pull_low, 1'b0);
    bus_send(8'h01, a1); bus_stop; wait_clk(5);
    check("R7 irq after stop", irq_pull_low, 1'b1);
    bus_start; bus_send(WR_B, a0); bus_send(8'h1A, a1); bus_send(8'h80, a2); wait_clk(10);
    check("R7 release held until stop", irq_pull_low, 1'b1);
    bus_stop; wait_clk(5);
    check("R9 bit7 releases irq", irq_pull_low, 1'b0);
    short_read(d);
    check("R9 bit7 clears events", d, 8'h00);
  endtask

  task automatic t_port_reset;
    int snap; logic ok; logic [7:0] d;
    snap = prst_cnt;
    reg_write(8'h1A, 8'h10, ok); wait_clk(5);
    check("R10 one port reset pulse", prst_cnt - snap, 1);
    reg_read(8'h1A, d, ok);
    check("R12 pushbutton reads zero", d, 8'h00);
  endtask

  task automatic t_sticky_ara;
    logic [7:0] d; logic a0;
    pulse_evt(8'h80); wait_clk(200);
    short_read(d);
    check("R5 event sticky", d, 8'h80);
    bus_start; bus_send(8'h19, a0); bus_recv(d); bus_stop;
    check("R11 alert address acked", a0, 1'b1);
    check("R11 alert reply", d, RD_B);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    wait_clk(5); rst = 0; wait_clk(5);
    t_reset;
    t_write_read;
    t_bad_addr;
    t_unimpl;
    t_events;
    t_in_txn;
    t_port_reset;
    t_sticky_ara;
    done = 1'b1;
    summary;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired before all scenarios finished");
      summary;
    end
  end
endmodule